// File: doc/BRIEF.md
# Bit-serial programming-link byte shifter

This block moves a short burst of command bytes to a target device over a three-wire serial programming link: a serial clock, a data line towards the target and a data line back from it. The host first loads up to eight bytes into an internal buffer through a simple byte-write port. It then pulses `start` with a byte count. The block clocks the bytes out most significant bit first. On the same serial clock it collects the target's reply bits into the register that is shifting out.

The serial clock speed is chosen per transfer by a host speed code. The block maps that code to a half-period expressed in timer ticks, where one tick is `TICK_DIV` system clock cycles. Each phase of the serial clock lasts one system cycle plus the tick count times `TICK_DIV`. The mapping is fixed for the four lowest codes. Higher codes use an integer shift-and-add formula chosen at build time by `FAST_CLK`. When the burst ends, the last received byte is held on `rx_byte` and `done` pulses for one cycle.

Top module: `isp_byte_shifter`

## Requirements
- R1: For a count of N (1 to 8), buffer slots 0 to N-1 are sent in slot order. Each byte is sent bit 7 first and uses exactly 8 serial clock pulses. A slot is written with `wr_data` at `wr_addr` when `wr_en` is high.
- R2: Each bit has a low phase of `sck` followed by a high phase. Both phases last L system cycles. `mosi` takes the new bit at the start of the low phase, on the cycle after `start` is sampled or on the cycle `sck` falls, and holds it through the high phase.
- R3: On the cycle `sck` rises, the block samples `miso` into bit 0 of the shift register as the register moves one place left. At completion `rx_byte` equals the last byte the target sent, with its first-sent bit in bit 7.
- R4: When `miso_invert` is 1, every sampled `miso` level is inverted before it enters the shift register.
- R5: A count of 0 produces no `sck` pulse and leaves `busy` low. It pulses `done` on the cycle after `start` and sets `rx_byte` to 0.
- R6: A count above 8 is treated as 8.
- R7: L = 1 + T * `TICK_DIV`, where T is the tick count. Speed codes 0 and 1 give T = 0, code 2 gives T = 1 and code 3 gives T = 2.
- R8: For a code n of 4 or more, T uses integer division. With `FAST_CLK` = 1, T = (n+1)/2 - (n+1)/8 + (n+1)/32. With `FAST_CLK` = 0, T = (n+1)/4 + (n+1)/16.
- R9: A `start` while `busy` is high has no effect. Speed code and count are taken only at the accepted `start`, so changing them during a transfer does not alter it.
- R10: `busy` is high from the cycle after an accepted `start` until the final `sck` falling edge. On that edge `busy` drops and `done` is high for exactly one cycle. When idle, `sck` and `mosi` are low.
- R11: During reset, `sck`, `mosi`, `busy`, `done` and `rx_byte` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Write strobe for the byte buffer |
| wr_addr | input | 3 | Buffer slot to write |
| wr_data | input | 8 | Byte to store |
| start | input | 1 | Launch a transfer (ignored while busy) |
| byte_count | input | 4 | Number of bytes to transfer, 0 to 8 (larger values clamp) |
| speed_code | input | 8 | Host speed code selecting the half-period |
| miso_invert | input | 1 | Invert the sampled return data |
| miso | input | 1 | Serial data from the target |
| sck | output | 1 | Serial clock to the target |
| mosi | output | 1 | Serial data to the target |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rx_byte | output | 8 | Last byte received |

## Verification
The hardest condition to reach from the ports is a second `start` that lands mid-burst together with a changed speed code and count. It must leave the ongoing clock train untouched. The bench reaches it by pulsing `start` a few cycles into a transfer while also moving both configuration inputs. A per-cycle expectation queue then catches any disturbance in `sck`, `mosi`, `busy` or `done`. A second instance built with the slower formula runs from the same inputs, and its busy time is measured to confirm that the build-time formula choice takes effect.

// File: rtl/isp_shift_pkg.sv
package isp_shift_pkg;

  localparam int BYTE_W    = 8;
  localparam int BIT_IDX_W = $clog2(BYTE_W);

  typedef enum logic [1:0] {
    SHF_IDLE  = 2'd0,
    SHF_SETUP = 2'd1,
    SHF_HOLD  = 2'd2
  } shf_state_e;

endpackage

// File: rtl/isp_speed_map.sv
// Maps a host speed code to a half-period expressed in timer ticks.
module isp_speed_map #(
  parameter int CODE_W   = 8,
  parameter int TICK_W   = 8,
  parameter bit FAST_CLK = 1'b1
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [TICK_W-1:0] ticks_o
);

  localparam int SUM_W  = CODE_W + 1;
  localparam int WIDE_W = (SUM_W > TICK_W) ? SUM_W : TICK_W;
  localparam logic [WIDE_W-1:0] TICK_MAX = WIDE_W'((2 ** TICK_W) - 1);

  logic [WIDE_W-1:0] np1;
  logic [WIDE_W-1:0] formula;
  logic [WIDE_W-1:0] mapped;

  assign np1 = WIDE_W'(code_i) + WIDE_W'(1);

  generate
    if (FAST_CLK) begin : g_fast
      assign formula = (np1 >> 1) - (np1 >> 3) + (np1 >> 5);
    end else begin : g_slow
      assign formula = (np1 >> 2) + (np1 >> 4);
    end
  endgenerate

  always_comb begin
    if (code_i < CODE_W'(2)) begin
      mapped = '0;
    end else if (code_i == CODE_W'(2)) begin
      mapped = WIDE_W'(1);
    end else if (code_i == CODE_W'(3)) begin
      mapped = WIDE_W'(2);
    end else begin
      mapped = formula;
    end
  end

  // saturate when the tick field is narrower than the formula result
  assign ticks_o = (mapped > TICK_MAX) ? {TICK_W{1'b1}} : mapped[TICK_W-1:0];

endmodule

// File: rtl/isp_phase_timer.sv
// Down-counter timing one serial clock phase in system cycles.
module isp_phase_timer #(
  parameter int PHASE_W = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic [PHASE_W-1:0] load_val_i,
  output logic               expired_o
);

  logic [PHASE_W-1:0] cnt_q;
  logic [PHASE_W-1:0] cnt_d;
  logic               cnt_en;

  always_comb begin
    cnt_en = load_i || (cnt_q != '0);
    if (load_i) begin
      cnt_d = load_val_i;
    end else begin
      cnt_d = cnt_q - PHASE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/isp_byte_buf.sv
// Small command byte store: one write port, one combinational read port.
module isp_byte_buf #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 3,
  parameter int IDX_W  = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en_i,
  input  logic [ADDR_W-1:0]               wr_addr_i,
  input  logic [isp_shift_pkg::BYTE_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]                rd_idx_i,
  output logic [isp_shift_pkg::BYTE_W-1:0] rd_data_o
);

  import isp_shift_pkg::*;

  logic [DEPTH*BYTE_W-1:0] flat;

  generate
    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
      logic              slot_we;
      logic [BYTE_W-1:0] slot_q;

      assign slot_we = wr_en_i && (wr_addr_i == ADDR_W'(s));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          slot_q <= '0;
        end else if (slot_we) begin
          slot_q <= wr_data_i;
        end
      end

      assign flat[s*BYTE_W +: BYTE_W] = slot_q;
    end
  endgenerate

  always_comb begin
    rd_data_o = '0;
    for (int j = 0; j < DEPTH; j++) begin
      if (rd_idx_i == IDX_W'(j)) begin
        rd_data_o = flat[j*BYTE_W +: BYTE_W];
      end
    end
  end

endmodule

// File: rtl/isp_byte_shifter.sv
// Bit-serial byte shifter for a three-wire programming link.
module isp_byte_shifter #(
  parameter int BUF_DEPTH = 8,
  parameter int CODE_W    = 8,
  parameter int TICK_W    = 8,
  parameter int TICK_DIV  = 4,
  parameter bit FAST_CLK  = 1'b1,
  localparam int ADDR_W   = $clog2(BUF_DEPTH),
  localparam int CNT_W    = $clog2(BUF_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              start,
  input  logic [CNT_W-1:0]  byte_count,
  input  logic [CODE_W-1:0] speed_code,
  input  logic              miso_invert,
  input  logic              miso,
  output logic              sck,
  output logic              mosi,
  output logic              busy,
  output logic              done,
  output logic [7:0]        rx_byte
);

  import isp_shift_pkg::*;

  localparam int PHASE_MAX = 1 + ((2 ** TICK_W) - 1) * TICK_DIV;
  localparam int PHASE_W   = $clog2(PHASE_MAX + 1);
  localparam logic [BIT_IDX_W-1:0] LAST_BIT = BIT_IDX_W'(BYTE_W - 1);

  // ---------------------------------------------------------------- state
  shf_state_e            state_q, state_d;
  logic [BYTE_W-1:0]     shift_q, shift_d;
  logic                  mosi_q, mosi_d;
  logic                  sck_q, sck_d;
  logic                  done_q, done_d;
  logic [BYTE_W-1:0]     rx_q, rx_d;
  logic [CNT_W-1:0]      idx_q, idx_d;
  logic [CNT_W-1:0]      total_q, total_d;
  logic [BIT_IDX_W-1:0]  bit_q, bit_d;
  logic [PHASE_W-1:0]    len_q, len_d;

  // ------------------------------------------------------- helper signals
  logic [TICK_W-1:0]     ticks;
  logic [PHASE_W-1:0]    new_len;
  logic [CNT_W-1:0]      count_cl;
  logic [CNT_W-1:0]      rd_idx;
  logic [BYTE_W-1:0]     rd_data;
  logic                  tmr_load;
  logic [PHASE_W-1:0]    tmr_val;
  logic                  tmr_expired;
  logic                  miso_s;
  logic                  xfer_en;
  logic                  byte_end;
  logic                  burst_end;

  isp_speed_map #(
    .CODE_W  (CODE_W),
    .TICK_W  (TICK_W),
    .FAST_CLK(FAST_CLK)
  ) u_map (
    .code_i (speed_code),
    .ticks_o(ticks)
  );

  isp_byte_buf #(
    .DEPTH (BUF_DEPTH),
    .ADDR_W(ADDR_W),
    .IDX_W (CNT_W)
  ) u_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en_i  (wr_en),
    .wr_addr_i(wr_addr),
    .wr_data_i(wr_data),
    .rd_idx_i (rd_idx),
    .rd_data_o(rd_data)
  );

  isp_phase_timer #(
    .PHASE_W(PHASE_W)
  ) u_tmr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (tmr_load),
    .load_val_i(tmr_val),
    .expired_o (tmr_expired)
  );

  assign new_len  = PHASE_W'(1) + PHASE_W'(ticks) * PHASE_W'(TICK_DIV);
  assign count_cl = (byte_count > CNT_W'(BUF_DEPTH)) ? CNT_W'(BUF_DEPTH) : byte_count;
  assign rd_idx   = (state_q == SHF_IDLE) ? '0 : (idx_q + CNT_W'(1));
  assign miso_s   = miso ^ miso_invert;
  assign byte_end = (bit_q == LAST_BIT);
  assign burst_end = byte_end && ((idx_q + CNT_W'(1)) == total_q);
  assign xfer_en  = start || (state_q != SHF_IDLE);

  // ------------------------------------------------------- next state
  always_comb begin
    state_d  = state_q;
    shift_d  = shift_q;
    mosi_d   = mosi_q;
    sck_d    = sck_q;
    done_d   = 1'b0;
    rx_d     = rx_q;
    idx_d    = idx_q;
    total_d  = total_q;
    bit_d    = bit_q;
    len_d    = len_q;
    tmr_load = 1'b0;
    tmr_val  = len_q - PHASE_W'(1);

    unique case (state_q)
      SHF_IDLE: begin
        if (start) begin
          if (count_cl == '0) begin
            done_d = 1'b1;
            rx_d   = '0;
          end else begin
            state_d  = SHF_SETUP;
            shift_d  = rd_data;
            mosi_d   = rd_data[BYTE_W-1];
            sck_d    = 1'b0;
            idx_d    = '0;
            total_d  = count_cl;
            bit_d    = '0;
            len_d    = new_len;
            tmr_load = 1'b1;
            tmr_val  = new_len - PHASE_W'(1);
          end
        end
      end

      SHF_SETUP: begin
        if (tmr_expired) begin
          state_d  = SHF_HOLD;
          sck_d    = 1'b1;
          shift_d  = {shift_q[BYTE_W-2:0], miso_s};
          tmr_load = 1'b1;
        end
      end

      SHF_HOLD: begin
        if (tmr_expired) begin
          sck_d = 1'b0;
          if (burst_end) begin
            state_d = SHF_IDLE;
            done_d  = 1'b1;
            rx_d    = shift_q;
            mosi_d  = 1'b0;
          end else if (byte_end) begin
            state_d  = SHF_SETUP;
            idx_d    = idx_q + CNT_W'(1);
            shift_d  = rd_data;
            mosi_d   = rd_data[BYTE_W-1];
            bit_d    = '0;
            tmr_load = 1'b1;
          end else begin
            state_d  = SHF_SETUP;
            bit_d    = bit_q + BIT_IDX_W'(1);
            mosi_d   = shift_q[BYTE_W-1];
            tmr_load = 1'b1;
          end
        end
      end

      default: begin
        state_d = SHF_IDLE;
        sck_d   = 1'b0;
        mosi_d  = 1'b0;
      end
    endcase
  end

  // ------------------------------------------------------- registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SHF_IDLE;
      shift_q <= '0;
      mosi_q  <= 1'b0;
      sck_q   <= 1'b0;
      idx_q   <= '0;
      total_q <= '0;
      bit_q   <= '0;
      len_q   <= '0;
    end else if (xfer_en) begin
      state_q <= state_d;
      shift_q <= shift_d;
      mosi_q  <= mosi_d;
      sck_q   <= sck_d;
      idx_q   <= idx_d;
      total_q <= total_d;
      bit_q   <= bit_d;
      len_q   <= len_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      rx_q   <= '0;
    end else begin
      done_q <= done_d;
      if (done_d) begin
        rx_q <= rx_d;
      end
    end
  end

  assign sck     = sck_q;
  assign mosi    = mosi_q;
  assign busy    = (state_q != SHF_IDLE);
  assign done    = done_q;
  assign rx_byte = rx_q;

endmodule

// File: rtl/isp_byte_shifter_chk.sv
// Port-level protocol checks, attached to every shifter instance.
module isp_byte_shifter_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [CNT_W-1:0] byte_count,
  input logic             sck,
  input logic             mosi,
  input logic             busy,
  input logic             done,
  input logic [7:0]       rx_byte
);

  // R10: no serial clock or data activity outside a transfer
  assert_sck_idle_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!sck && !mosi));

  // R10: completion is a single-cycle pulse and never overlaps busy
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !done);

  assert_done_not_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R2: within a transfer the data line only moves as the clock falls
  assert_mosi_change_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && (mosi != $past(mosi))) |-> $fell(sck));

  // R5: an empty burst completes at once with a zero result
  assert_zero_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && (byte_count == '0)) |=> (done && !busy && (rx_byte == 8'h00)));

  // R9: a start during a transfer neither restarts nor aborts it
  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy || done));

  assert_busy_origin_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

endmodule

bind isp_byte_shifter isp_byte_shifter_chk #(
  .CNT_W(CNT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .byte_count(byte_count),
  .sck       (sck),
  .mosi      (mosi),
  .busy      (busy),
  .done      (done),
  .rx_byte   (rx_byte)
);

// File: tb/isp_byte_shifter_test.sv
module isp_byte_shifter_test;

  localparam int CLK_PERIOD = 10;
  localparam int TDIV       = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [2:0] wr_addr;
  logic [7:0] wr_data;
  logic       start;
  logic [3:0] byte_count;
  logic [7:0] speed_code;
  logic       miso_invert;
  logic       miso;
  logic       sck, mosi, busy, done;
  logic [7:0] rx_byte;
  logic       s_sck, s_mosi, s_busy, s_done;
  logic [7:0] s_rx;

  always #(CLK_PERIOD/2) clk = ~clk;

  isp_byte_shifter #(.TICK_DIV(TDIV), .FAST_CLK(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .start(start), .byte_count(byte_count), .speed_code(speed_code),
    .miso_invert(miso_invert), .miso(miso), .sck(sck), .mosi(mosi),
    .busy(busy), .done(done), .rx_byte(rx_byte));

  isp_byte_shifter #(.TICK_DIV(TDIV), .FAST_CLK(1'b0)) uut_slow (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .start(start), .byte_count(byte_count), .speed_code(speed_code),
    .miso_invert(1'b0), .miso(1'b0), .sck(s_sck), .mosi(s_mosi),
    .busy(s_busy), .done(s_done), .rx_byte(s_rx));

  int tests_run    = 0;
  int tests_failed = 0;

  task automatic check(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    tests_run++;
    if (got !== exp) begin
      tests_failed++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  // ---------------------------------------------------- target model
  logic [7:0] tx_mem [8];
  logic [7:0] reply  [8];
  logic [7:0] got_b  [8];
  int tgt_k = 0;
  int tgt_n = 0;

  always @* begin
    if (tgt_k < tgt_n * 8) miso = reply[tgt_k / 8][7 - (tgt_k % 8)];
    else                   miso = 1'b0;
  end

  always @(posedge sck) begin
    if (tgt_k < 64) got_b[tgt_k / 8][7 - (tgt_k % 8)] <= mosi;
  end

  always @(negedge sck) tgt_k <= tgt_k + 1;

  // ------------------------------------- per-cycle expectation queue
  // bit0 sck, bit1 busy, bit2 done, bit3 mosi value, bit4 mosi checked
  int exp_q[$];
  bit cmp_on = 1'b0;

  always @(negedge clk) begin
    int         e;
    logic [4:0] g;
    if (cmp_on) begin
      if (exp_q.size() > 0) e = exp_q.pop_front();
      else                  e = 16;
      g = {e[4], (e[4] ? mosi : e[3]), done, busy, sck};
      check("R2/R10", "cycle sck/busy/done/mosi", 32'(g), 32'(e[4:0]));
    end
  end

  int slow_cnt = 0;
  always @(negedge clk) if (s_busy) slow_cnt++;

  function automatic int ticks_of(input int code, input bit fast);
    int n;
    n = code + 1;
    if (code < 2)  return 0;
    if (code == 2) return 1;
    if (code == 3) return 2;
    if (fast)      return n/2 - n/8 + n/32;
    return n/4 + n/16;
  endfunction

  task automatic write_slot(input int a, input logic [7:0] d);
    @(negedge clk); #1;
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = d; tx_mem[a] = d;
    @(negedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic set_reply(input int seed);
    for (int b = 0; b < 8; b++) reply[b] = 8'((seed * 37 + b * 91 + 5) ^ (b << 4));
  endtask

  task automatic run_xfer(input string req, input int n, input int code,
                          input bit inv, input bit poke);
    int nc, len;
    logic [7:0] exp_rx;
    nc  = (n > 8) ? 8 : n;
    len = 1 + ticks_of(code, 1'b1) * TDIV;
    @(negedge clk); #1;
    tgt_k = 0; tgt_n = nc;
    for (int b = 0; b < 8; b++) got_b[b] = 8'h00;
    byte_count = 4'(n); speed_code = 8'(code); miso_invert = inv;
    for (int b = 0; b < nc; b++) begin
      for (int i = 7; i >= 0; i--) begin
        int m;
        m = tx_mem[b][i];
        repeat (len) exp_q.push_back(2 | (m << 3) | 16);
        repeat (len) exp_q.push_back(1 | 2 | (m << 3) | 16);
      end
    end
    exp_q.push_back(4 | 16);
    start = 1'b1;
    @(negedge clk); #1;
    start = 1'b0;
    if (poke) begin
      repeat (5) @(negedge clk);
      #1;
      start = 1'b1; byte_count = 4'd3; speed_code = 8'd0;
      @(negedge clk); #1;
      start = 1'b0;
    end
    while (exp_q.size() > 0) @(negedge clk);
    #1;
    if (nc == 0)  exp_rx = 8'h00;
    else if (inv) exp_rx = ~reply[nc-1];
    else          exp_rx = reply[nc-1];
    check(req, "rx_byte after burst (R3)", 32'(rx_byte), 32'(exp_rx));
    for (int b = 0; b < nc; b++)
      check("R1", "byte seen by target", 32'(got_b[b]), 32'(tx_mem[b]));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests_failed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; start = 1'b0;
    byte_count = '0; speed_code = '0; miso_invert = 1'b0;
    for (int b = 0; b < 8; b++) begin tx_mem[b] = 8'h00; got_b[b] = 8'h00; end
    set_reply(0);
    repeat (3) @(negedge clk);
    check("R11", "reset sck", 32'(sck), 0);
    check("R11", "reset mosi", 32'(mosi), 0);
    check("R11", "reset busy", 32'(busy), 0);
    check("R11", "reset done", 32'(done), 0);
    check("R11", "reset rx_byte", 32'(rx_byte), 0);
    #1 rst_n = 1'b1;
    @(negedge clk);
    cmp_on = 1'b1;

    write_slot(0, 8'hA5); write_slot(1, 8'h3C); write_slot(2, 8'h81);
    write_slot(3, 8'h7E); write_slot(4, 8'h0F); write_slot(5, 8'hF0);
    write_slot(6, 8'h55); write_slot(7, 8'hC3);

    set_reply(1); run_xfer("R3", 1, 0, 1'b0, 1'b0);   // R1 R3 R7 single byte
    set_reply(2); run_xfer("R7", 4, 2, 1'b0, 1'b0);   // R7 code 2
    set_reply(3); run_xfer("R4", 3, 3, 1'b1, 1'b0);   // R4 inversion, code 3
    set_reply(4); run_xfer("R7", 2, 1, 1'b0, 1'b0);   // R7 code 1 as code 0
    set_reply(5); run_xfer("R8", 2, 10, 1'b0, 1'b0);  // R8 fast formula
    run_xfer("R5", 0, 2, 1'b0, 1'b0);                 // R5 empty burst
    set_reply(6); run_xfer("R6", 12, 0, 1'b0, 1'b0);  // R6 clamp to 8
    set_reply(7); run_xfer("R9", 2, 2, 1'b0, 1'b1);   // R9 mid-burst start
    set_reply(8); run_xfer("R4", 8, 0, 1'b1, 1'b0);   // R4 full buffer inverted

    // R8: slow-formula build, code 20 -> 6 ticks -> 25-cycle phases
    while (s_busy) @(negedge clk);
    slow_cnt = 0;
    set_reply(9); run_xfer("R8", 1, 20, 1'b0, 1'b0);
    while (s_busy) @(negedge clk);
    check("R8", "slow build busy cycles", 32'(slow_cnt),
          32'(16 * (1 + ticks_of(20, 1'b0) * TDIV)));

    repeat (4) @(negedge clk);
    cmp_on = 1'b0;
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

endmodule